// File: doc/BRIEF.md
# Half-Step Pixel Clock Divider

This block turns a fast display source clock into a pixel-rate clock-enable. It emits one single-cycle pulse per pixel. The divide ratio is set by an 8-bit code in 7.1 fixed point, where the lowest bit is worth one half. The code carries an offset of two, so the ratio is (code + 2) / 2 source cycles per pixel. Code 0 divides by one, code 1 by one and a half, and code 254 by 128. Downstream logic in the source clock domain uses the pulse as its enable. No second clock is built.

Some ratios have a half step, which happens when (code + 2) is odd. For these the block spaces its pulses alternately by the floor and the ceiling of the ratio, so the long-run rate is exact. A phase accumulator counted in half source cycles produces this pattern. A new code is taken up only when the current pixel period ends. While enable is low the output is held low and the accumulator is cleared.

The package also holds a helper function. It takes the source and target frequencies and returns the code: twice their quotient, rounded to nearest, less two. The result is clamped to the code range.

Top module: `halfstep_pixdiv`

## Requirements
- R1: While reset is high and on the first cycle after it, `pix_ce` is low, and the active code and phase start at zero.
- R2: With enable held high and the code constant, the number of pulses over the first k enabled clock edges equals floor(2k / (code + 2)).
- R3: With code 0, `pix_ce` is high on every clock cycle once enabled.
- R4: When (code + 2) is even, pulses are evenly spaced (code + 2) / 2 cycles apart.
- R5: When (code + 2) is odd, pulse spacings alternate between floor((code + 2) / 2) and ceil((code + 2) / 2) cycles.
- R6: After enable rises, the first pulse is seen on the ceil((code + 2) / 2)-th clock edge that samples enable high.
- R7: A code changed while enabled is taken up only at the edge that produces a pulse, so the period in progress completes with the old ratio.
- R8: An edge that samples enable low drives `pix_ce` low and clears the phase. A later enable restarts exactly as from reset, with the code present while enable was low.
- R9: The helper `calc_div_code(src, pix, max)` returns round_half_up(2 * src / pix) - 2, clamped to the range 0 to max. It returns max when pix is 0.
- R10: While enabled, the gap between pulses never exceeds ceil((2^CODE_W + 1) / 2) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the output low and clears the phase |
| div_code | input | CODE_W | Divider code in 7.1 format with an offset of 2 |
| pix_ce | output | 1 | Registered one-cycle pixel clock-enable pulse |

## Verification
Directed codes 0, 1, 2, 254 and 255 cover divide-by-one, the smallest half step, the smallest even ratio and the two longest periods. Odd codes separate a correct alternating spacing from a truncated or rounded single spacing. Random segments with random codes, random enable drops and codes changed mid-period distinguish a code latched at period end from one used at once. They also show whether the phase is truly cleared on enable loss. Frequency pairs that round up, round down, fall below the offset and exceed the range check the helper's rounding and clamps.

// File: rtl/halfstep_div_pkg.sv
package halfstep_div_pkg;

  // Code for a given source and pixel frequency: round(2*src/pix) - 2,
  // rounded half up and clamped to [0, code_max].
  function automatic int unsigned calc_div_code(input longint unsigned src_hz,
                                                input longint unsigned pix_hz,
                                                input int unsigned     code_max);
    longint unsigned twice_q;
    if (pix_hz == 0) return code_max;
    twice_q = (2 * src_hz + pix_hz / 2) / pix_hz;
    if (twice_q < 2) return 0;
    if (twice_q - 2 > longint'(code_max)) return code_max;
    return int'(twice_q - 2);
  endfunction

endpackage

// File: rtl/halfstep_code_hold.sv
module halfstep_code_hold #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);
  // Active code only moves at a period boundary or while idle.
  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (load) code_q <= code_in;
  end
endmodule

// File: rtl/halfstep_phase.sv
module halfstep_phase #(
  parameter int PH_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PH_W-1:0] ratio,   // period length in half source cycles
  output logic            hit,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] acc_q;
  logic [PH_W-1:0] acc_nxt;

  // Each source cycle is two half-units.
  assign acc_nxt = acc_q + PH_W'(2);
  assign hit     = run && (acc_nxt >= ratio);
  assign phase   = acc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) acc_q <= '0;
    else if (hit)    acc_q <= acc_nxt - ratio;
    else             acc_q <= acc_nxt;
  end
endmodule

// File: rtl/halfstep_pixdiv.sv
module halfstep_pixdiv #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] div_code,
  output logic              pix_ce
);
  localparam int PH_W = CODE_W + 2;

  logic [CODE_W-1:0] act_code;
  logic [PH_W-1:0]   ratio;
  logic [PH_W-1:0]   phase_q;
  logic              hit;
  logic              load_code;
  logic              ce_q;

  assign ratio     = PH_W'(act_code) + PH_W'(2);
  assign load_code = !en || hit;

  halfstep_code_hold #(.CODE_W(CODE_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load    (load_code),
    .code_in (div_code),
    .code_q  (act_code)
  );

  halfstep_phase #(.PH_W(PH_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .run   (en),
    .ratio (ratio),
    .hit   (hit),
    .phase (phase_q)
  );

  always_ff @(posedge clk) begin
    if (rst) ce_q <= 1'b0;
    else     ce_q <= hit;
  end

  assign pix_ce = ce_q;
endmodule

// File: rtl/halfstep_pixdiv_chk.sv
module halfstep_pixdiv_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [CODE_W-1:0] div_code,
  input logic              pix_ce,
  input logic [CODE_W-1:0] act_code,
  input logic [CODE_W+1:0] phase_q
);
  localparam int PH_W    = CODE_W + 2;
  localparam int MAX_GAP = ((1 << CODE_W) + 2) / 2;

  logic [PH_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || !en || pix_ce) gap_q <= '0;
    else                      gap_q <= gap_q + PH_W'(1);
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pix_ce);                                                   // R8

  AST_DIV_ONE: assert property (@(posedge clk) disable iff (rst)
    (!en && div_code == '0) ##1 (en && div_code == '0) |=> pix_ce);     // R3

  AST_CODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_code) |-> ($past(!en) || pix_ce));                     // R7

  AST_PHASE_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    phase_q < (PH_W'(act_code) + PH_W'(2)));                            // R2

  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(gap_q) <= MAX_GAP);                                            // R10
endmodule

bind halfstep_pixdiv halfstep_pixdiv_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .div_code (div_code),
  .pix_ce   (pix_ce),
  .act_code (act_code),
  .phase_q  (phase_q)
);

// File: tb/test_halfstep_pixdiv.sv
module test_halfstep_pixdiv;
  import halfstep_div_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CODE_W-1:0] div_code = '0;
  logic pix_ce;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state, in half source cycles
  int mp = 0;
  int mact = 0;
  bit exp_ce = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halfstep_pixdiv #(.CODE_W(CODE_W)) i_halfstep_pixdiv (
    .clk(clk), .rst(rst), .en(en), .div_code(div_code), .pix_ce(pix_ce)
  );

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // drive one cycle, model the edge, check after the edge
  task automatic tick(input bit e, input int c);
    string tag;
    en = e;
    div_code = CODE_W'(c);
    if (!e)                 tag = "R8";
    else if (c != mact)     tag = "R7";
    else if (mact == 0)     tag = "R3";
    else if (mact % 2 == 1) tag = "R5";
    else                    tag = "R4";
    if (!e) begin
      mp = 0; mact = c; exp_ce = 0;
    end else if (mp + 2 >= mact + 2) begin
      exp_ce = 1; mp = mp + 2 - (mact + 2); mact = c;
    end else begin
      exp_ce = 0; mp = mp + 2;
    end
    @(negedge clk);
    check(tag, longint'(pix_ce), longint'(exp_ce));
  endtask

  function automatic int ref_code(input real s, input real p);
    int q;
    if (p == 0.0) return 255;
    q = $rtoi($floor(2.0 * s / p + 0.5)) - 2;
    if (q < 0) return 0;
    if (q > 255) return 255;
    return q;
  endfunction

  task automatic first_pulse(input int c);
    int edges = 0;
    int npulse = 0;
    int k = 0;
    tick(0, c);
    while (npulse == 0 && edges < 300) begin
      tick(1, c);
      edges++;
      if (pix_ce) npulse++;
    end
    check("R6", edges, ((c + 2) + 1) / 2);
    tick(0, c);
    npulse = 0;
    for (int i = 0; i < 3 * (c + 2); i++) begin
      tick(1, c);
      k++;
      if (pix_ce) npulse++;
    end
    check("R2", npulse, (2 * k) / (c + 2));
  endtask

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check("R1", pix_ce, 0);
    rst = 0;
    @(negedge clk);
    check("R1", pix_ce, 0);

    // R9 helper rounding and clamps
    check("R9", calc_div_code(600000000, 100000000, 255), ref_code(600.0e6, 100.0e6));
    check("R9", calc_div_code(600000000, 70000000, 255),  ref_code(600.0e6, 70.0e6));
    check("R9", calc_div_code(600000000, 480000000, 255), ref_code(600.0e6, 480.0e6));
    check("R9", calc_div_code(600000000, 700000000, 255), 0);
    check("R9", calc_div_code(600000000, 1000000, 255),   255);
    check("R9", calc_div_code(600000000, 0, 255),         255);

    // directed corners
    first_pulse(0);
    first_pulse(1);
    first_pulse(2);
    first_pulse(5);
    first_pulse(254);
    first_pulse(255);

    // R10 longest gap with code 255
    begin
      int gap = 0;
      int maxgap = 0;
      tick(0, 255);
      for (int i = 0; i < 700; i++) begin
        tick(1, 255);
        if (pix_ce) gap = 0; else gap++;
        if (gap > maxgap) maxgap = gap;
      end
      check("R10", (maxgap <= 128) ? 1 : 0, 1);
    end

    // random segments with mid-run code changes and enable drops
    for (int s = 0; s < 60; s++) begin
      int c = $urandom_range(0, 40);
      int len = $urandom_range(20, 400);
      if (s % 10 == 9) c = $urandom_range(200, 255);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, 99) < 2) c = $urandom_range(0, 40);
        tick(($urandom_range(0, 99) < 3) ? 1'b0 : 1'b1, c);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule